// File: doc/BRIEF.md
# Alarm Status and Interrupt Register

This block is the control and status register pair of a real-time-clock controller. The control byte holds the alarm interrupt enable, a two-bit selector for the analog converter input, a write-protect bit, an oscillator-disable bit and two divider bits. The status byte holds a conversion-update warning flag, a low-battery flag and the alarm interrupt request flag. The time counter, the alarm comparator, the converter and the battery comparator sit outside the block. They appear only as a one-cycle match strobe, a battery comparator level and a result-load strobe that this block generates.

An alarm match sets the request flag. The flag drives an active-high interrupt pin only while the enable bit is set. Software clears the flag by reading or writing any alarm register; neither the status nor the control register has that effect. A free-running tick counter schedules converter refreshes. Before each refresh, the update flag rises for a fixed warning window, so software knows a result is about to change.

Top module: `alarm_status_irq`

## Requirements
- R1: After reset, the control register reads 0x70 (divider bits [6:5]=11, oscillator-disable bit [4]=1, write-protect bit [3]=0, select [2:1]=00, enable [0]=0). With the battery input low, the status register reads 0x00 and irq_out is 0.
- R2: A write to CTRL_ADDR stores wdata[6:0], and a read returns it combinationally. Bit 7 always reads 0.
- R3: ain_en decodes the select bits [2:1] of the control register: 00 gives 000, 01 gives 001, 10 gives 010 and 11 gives 100.
- R4: A cycle with alarm_hit high sets the request flag, status bit 0, from the next cycle on. With no hit and no alarm access the flag holds its value.
- R5: irq_out is 1 exactly when the request flag and the enable bit (control bit 0) are both 1.
- R6: A read or write to any address in ALM_BASE..ALM_BASE+ALM_CNT-1 clears the request flag. Accesses to the control or status addresses leave it unchanged.
- R7: When alarm_hit and an alarm-register access occur in the same cycle, the flag is set.
- R8: Status bit 6 follows batt_low_in after SYNC_STAGES clock edges.
- R9: Status bits 5 to 1 always read 0. Unmapped and alarm addresses read 0x00 from this block.
- R10: conv_load pulses for one cycle whenever the tick counter completes a period, which is PERIOD_TICKS-1 cycles after reset release and then every PERIOD_TICKS cycles. Status bit 7 is 1 during the WARN_TICKS cycles that end with that pulse.
- R11: Status bit 7 is 0 in the cycle after each conv_load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| alarm_hit | input | 1 | One-cycle time-equals-alarm strobe |
| batt_low_in | input | 1 | Backup-supply comparator level, asynchronous |
| irq_out | output | 1 | Active-high interrupt |
| ain_en | output | 3 | One-hot converter input enable, all zero for none |
| conv_load | output | 1 | Converter result-load strobe |

## Verification
The assertions assume that bus_wr and bus_rd are never high together. They also assume that alarm_hit is a clean one-cycle strobe sampled on the clock. The random stimulus picks one of write, read or idle on each cycle, so the two strobes are exclusive by construction. The battery input changes only at negative edges, so the synchronizer sees legal levels. Directed cases place a hit and an alarm access in the same cycle, and toggle the enable while the flag is set.

// File: rtl/asir_pkg.sv
package asir_pkg;
   typedef struct packed {
      logic [1:0] div;
      logic       osc_off;
      logic       wprot;
      logic [1:0] sel;
      logic       aie;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{div: 2'b11, osc_off: 1'b1, wprot: 1'b0, sel: 2'b00, aie: 1'b0};

   function automatic logic [2:0] sel_decode(input logic [1:0] s);
      logic [2:0] r;
      r = '0;
      if (s != 2'b00) r[s - 2'd1] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/asir_sync.sv
module asir_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad
         $error("asir_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= d;
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/asir_irq_flag.sv
module asir_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
endmodule

// File: rtl/asir_conv_timer.sv
module asir_conv_timer #(
   parameter int PERIOD_TICKS = 1000,
   parameter int WARN_TICKS   = 500
) (
   input  logic clk,
   input  logic rst_n,
   output logic upd_o,
   output logic load_o
);
   localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);
   localparam logic [CNT_W-1:0] PRE  = CNT_W'(PERIOD_TICKS - WARN_TICKS - 1);

   generate
      if (PERIOD_TICKS < 2) begin : g_bad_p
         $error("asir_conv_timer: PERIOD_TICKS must be at least 2");
      end
      if (WARN_TICKS < 1 || WARN_TICKS >= PERIOD_TICKS) begin : g_bad_w
         $error("asir_conv_timer: WARN_TICKS must be in 1..PERIOD_TICKS-1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           upd_o <= 1'b0;
      else if (cnt == PRE)  upd_o <= 1'b1;
      else if (cnt == LAST) upd_o <= 1'b0;

   assign load_o = (cnt == LAST);
endmodule

// File: rtl/alarm_status_irq.sv
module alarm_status_irq
   import asir_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int ALM_BASE     = 0,
   parameter int ALM_CNT      = 3,
   parameter int CTRL_ADDR    = 8,
   parameter int STAT_ADDR    = 9,
   parameter int PERIOD_TICKS = 1000,
   parameter int WARN_TICKS   = 500,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              alarm_hit,
   input  logic              batt_low_in,
   output logic              irq_out,
   output logic [2:0]        ain_en,
   output logic              conv_load
);
   localparam int ASPACE = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(ALM_BASE);
   localparam logic [ADDR_W:0]   A_CNT  = (ADDR_W+1)'(ALM_CNT);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   generate
      if (ALM_CNT < 1 || ALM_BASE + ALM_CNT > ASPACE) begin : g_bad_alm
         $error("alarm_status_irq: alarm window out of address space");
      end
      if (CTRL_ADDR >= ASPACE || STAT_ADDR >= ASPACE || CTRL_ADDR == STAT_ADDR) begin : g_bad_reg
         $error("alarm_status_irq: bad control/status address");
      end
      if ((CTRL_ADDR >= ALM_BASE && CTRL_ADDR < ALM_BASE + ALM_CNT) ||
          (STAT_ADDR >= ALM_BASE && STAT_ADDR < ALM_BASE + ALM_CNT)) begin : g_overlap
         $error("alarm_status_irq: register overlaps alarm window");
      end
   endgenerate

   // address decode
   logic [ADDR_W-1:0] alm_off;
   logic              alm_access;
   assign alm_off    = bus_addr - A_BASE;
   assign alm_access = (bus_wr | bus_rd) && ({1'b0, alm_off} < A_CNT);

   // control register
   ctrl_t ctrl_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           ctrl_q <= CTRL_RESET;
      else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[6:0]);

   // request flag
   logic irq_flag;
   asir_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (alarm_hit),
      .clr_i (alm_access),
      .flag_o(irq_flag)
   );

   // battery level synchronizer
   logic batt_low_s;
   asir_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (batt_low_in),
      .q    (batt_low_s)
   );

   // converter refresh sequencing
   logic upd_flag;
   asir_conv_timer #(.PERIOD_TICKS(PERIOD_TICKS), .WARN_TICKS(WARN_TICKS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_o (upd_flag),
      .load_o(conv_load)
   );

   assign irq_out = irq_flag & ctrl_q.aie;
   assign ain_en  = sel_decode(ctrl_q.sel);

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_addr == A_CTRL)      bus_rdata = {1'b0, ctrl_q};
      else if (bus_addr == A_STAT) bus_rdata = {upd_flag, batt_low_s, 5'b00000, irq_flag};
   end
endmodule

// File: rtl/alarm_status_irq_chk.sv
module alarm_status_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic       alarm_hit,
   input logic       alm_acc,
   input logic       irq_flag,
   input logic       aie,
   input logic       irq_out,
   input logic [2:0] ain_en,
   input logic       upd_flag,
   input logic       conv_load
);
   a_r4_set: assert property (@(posedge clk) disable iff (!rst_n) alarm_hit |=> irq_flag);
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_hit && !alm_acc) |=> $stable(irq_flag));
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_acc && !alarm_hit) |=> !irq_flag);
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_acc && alarm_hit) |=> irq_flag);
   a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> (irq_flag && aie));
   a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ain_en));
   a_r10_warned: assert property (@(posedge clk) disable iff (!rst_n) conv_load |-> upd_flag);
   a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n) conv_load |=> !upd_flag);
   a_r10_single: assert property (@(posedge clk) disable iff (!rst_n) conv_load |=> !conv_load);
   a_bus_excl: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd));
endmodule

bind alarm_status_irq alarm_status_irq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .alarm_hit(alarm_hit),
   .alm_acc  (alm_access),
   .irq_flag (irq_flag),
   .aie      (ctrl_q.aie),
   .irq_out  (irq_out),
   .ain_en   (ain_en),
   .upd_flag (upd_flag),
   .conv_load(conv_load)
);

// File: tb/alarm_status_irq_test.sv
`timescale 1ns/1ps
module alarm_status_irq_test;
   localparam int P = 1000;
   localparam int W = 500;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       alarm_hit = 1'b0, batt_low_in = 1'b0;
   logic       irq_out, conv_load;
   logic [2:0] ain_en;

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model
   logic [6:0] m_ctrl = 7'h70;
   logic       m_irqf = 0, m_s1 = 0, m_s2 = 0, m_upd = 0;
   int         m_cnt = 0;

   always #2.5 clk = ~clk;

   alarm_status_irq uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_hit(alarm_hit),
      .batt_low_in(batt_low_in), .irq_out(irq_out), .ain_en(ain_en), .conv_load(conv_load)
   );

   function automatic logic [7:0] exp_rdata(input logic [3:0] a);
      if (a == 4'd8) return {1'b0, m_ctrl};
      if (a == 4'd9) return {m_upd, m_s2, 5'b0, m_irqf};
      return 8'h00;
   endfunction

   function automatic logic [2:0] exp_ain(input logic [1:0] s);
      case (s)
         2'd1: return 3'b001;
         2'd2: return 3'b010;
         2'd3: return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one cycle at the negative edge, check, then advance model at the posedge
   task automatic step(input bit wr, input bit rd, input logic [3:0] a, input logic [7:0] wd,
                       input bit hit, input bit lb, input string tag);
      bit acc;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; alarm_hit = hit; batt_low_in = lb;
      #1;
      check(tag, bus_rdata, exp_rdata(a));
      check("R5", {7'b0, irq_out}, {7'b0, m_irqf & m_ctrl[0]});
      check("R3", {5'b0, ain_en}, {5'b0, exp_ain(m_ctrl[2:1])});
      check("R10", {7'b0, conv_load}, {7'b0, (m_cnt == P-1) ? 1'b1 : 1'b0});
      @(posedge clk);
      acc = (wr || rd) && (a < 4'd3);
      if (hit) m_irqf = 1; else if (acc) m_irqf = 0;
      if (wr && a == 4'd8) m_ctrl = wd[6:0];
      m_s2 = m_s1; m_s1 = lb;
      if (m_cnt == P-W-1) m_upd = 1; else if (m_cnt == P-1) m_upd = 0;
      m_cnt = (m_cnt == P-1) ? 0 : m_cnt + 1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      #1;
      check("R1", bus_rdata, 8'h00);          // addr 0 reads zero
      check("R1", {7'b0, irq_out}, 8'h00);
      rst_n = 1'b1;
      // R1: reset values of control and status
      step(0, 1, 4'd8, 8'h00, 0, 0, "R1");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R1");
      // R2: write/read control, bit 7 ignored
      step(1, 0, 4'd8, 8'hFF, 0, 0, "R2");
      step(0, 1, 4'd8, 8'h00, 0, 0, "R2");
      // R4: hit sets flag, R5: irq with enable
      step(0, 0, 4'd9, 8'h00, 1, 0, "R4");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R4");
      // R6: status and control access do not clear
      step(0, 1, 4'd9, 8'h00, 0, 0, "R6");
      step(1, 0, 4'd8, 8'h07, 0, 0, "R6");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R6");
      // R5: disable enable with flag set
      step(1, 0, 4'd8, 8'h06, 0, 0, "R5");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R5");
      step(1, 0, 4'd8, 8'h01, 0, 0, "R5");
      // R6: alarm read clears
      step(0, 1, 4'd2, 8'h00, 0, 0, "R6");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R6");
      // R7: simultaneous hit and alarm write
      step(1, 0, 4'd0, 8'h55, 1, 0, "R7");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R7");
      // R8: battery flag through synchronizer
      step(0, 1, 4'd9, 8'h00, 0, 1, "R8");
      step(0, 1, 4'd9, 8'h00, 0, 1, "R8");
      step(0, 1, 4'd9, 8'h00, 0, 1, "R8");
      step(0, 1, 4'd9, 8'h00, 0, 0, "R8");
      // random traffic spanning several refresh periods: R9, R10, R11 observed via status
      for (int i = 0; i < 3200; i++) begin
         int op;
         logic [3:0] a;
         bit lb;
         op = $urandom % 3;
         a  = 4'($urandom % 16);
         if (($urandom % 4) == 0) a = 4'd9;
         lb = batt_low_in;
         if (($urandom % 50) == 0) lb = ~lb;
         step(op == 0, op == 1, a, 8'($urandom), ($urandom % 6) == 0, lb,
              (a == 4'd9) ? "R9_R11" : "R2");
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule